// File: doc/BRIEF.md
# 9/7 Wavelet Analysis Filter Bank (one level, one dimension)

This block performs a single level of the biorthogonal 9/7 wavelet analysis on a block of unsigned pixels. It splits the block into approximation (low-pass) and detail (high-pass) coefficients and returns them interleaved, one pair per two input samples. No multiplier is used. Samples that share a coefficient are first summed by a folding stage. Each quantized coefficient is a short list of signed powers of two, applied as fixed shifts. All shifted terms are reduced by a carry-save array and resolved by one final adder.

A block of `BLK_LEN` samples is collected through a valid/ready input. At the block edges the samples are mirrored about the first and last sample, without repeating them. The coefficients are then streamed out at one per cycle, with a tag bit that separates the two subbands. The parameter `TRUNC_COLS` makes the result approximate: each shifted term loses its lowest columns, and a constant bias added in the array compensates for the lost value on average. With `TRUNC_COLS = 0` the result is exact.

Top module: `dwt97_analysis`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle at that edge: `out_valid` = 0, `in_ready` = 1, and any partly collected block is discarded.
- R2: In idle, `in_ready` is 1. A sample is taken on each rising edge where `in_valid` and `in_ready` are both 1. Cycles with `in_valid` = 0 may be mixed in freely. `in_ready` drops at the edge that takes the `BLK_LEN`-th sample.
- R3: While `in_ready` is 0, the values on `in_valid` and `in_data` have no effect on any later output.
- R4: `out_valid` is 0 one cycle after the last sample of a block is taken. It is then 1 for exactly `BLK_LEN` consecutive cycles. `in_ready` is 1 again during the final output cycle.
- R5: Output j of a block (j = 0..`BLK_LEN`-1) has `out_hi` = j mod 2. Even j is the low-pass coefficient centred on sample x[j]. Odd j is the high-pass coefficient centred on sample x[j].
- R6: With `TRUNC_COLS` = 0, a low-pass output equals exactly 154·x[c] + 68·(x[c-1]+x[c+1]) − 20·(x[c-2]+x[c+2]) − 4·(x[c-3]+x[c+3]) + 7·(x[c-4]+x[c+4]). This is a signed value with 8 fractional bits.
- R7: With `TRUNC_COLS` = 0, a high-pass output equals exactly 143·x[c] − 76·(x[c±1] summed) − 7·(x[c±2] summed) + 12·(x[c±3] summed). This is also a signed value with 8 fractional bits.
- R8: Indices outside the block are mirrored: x[−i] = x[i] and x[N−1+i] = x[N−1−i], where N = `BLK_LEN`.
- R9: With `TRUNC_COLS` = T > 0, every output differs from the exact value of R6/R7 by at most 11·2^T.
- R10: With `TRUNC_COLS` = T, the error averaged over uniformly random pixels has magnitude at most 2^T/2. The bias is what achieves this.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block is collecting samples |
| in_data | input | SAMPLE_W | Unsigned pixel |
| out_valid | output | 1 | Coefficient present |
| out_hi | output | 1 | 0 = low-pass, 1 = high-pass |
| out_data | output | OUT_W | Signed coefficient, 8 fractional bits |

## Verification
Let edge E be the one that takes the last sample. The first coefficient is registered at edge E+1, and coefficient j at edge E+1+j. The bench therefore checks that `out_valid` is still 0 at the falling edge after E, and compares coefficient j at the falling edge after E+1+j. An exact instance and a truncated instance run in lockstep on the same stimulus. The exact instance is compared with an arithmetic model over a full sweep of impulse positions and the other patterns. Garbage is offered on every refused cycle, and a reset is applied in the middle of a block.

// File: rtl/dwt97_pkg.sv
`timescale 1ns/1ps
// dwt97_pkg: signed-digit coefficient tables and bias arithmetic for the
// 9/7 analysis datapath. Coefficients are scaled by 256 (8 fractional bits).
// Assumes at most 11 signed-digit terms per band and shifts below 8.
package dwt97_pkg;

    localparam int NUM_GROUPS = 5;   // folded tap groups: centre plus 4 pairs
    localparam int NUM_SLOTS  = 11;  // signed-digit terms per band
    localparam int WIN_LEN    = 9;   // samples seen by the widest filter

    typedef struct packed {
        logic       en;   // slot in use
        logic       neg;  // subtract this term
        logic [2:0] grp;  // folded group feeding the term
        logic [2:0] shf;  // left shift (power of two)
    } sd_term_t;

    function automatic sd_term_t mk_term(input bit e, input bit n, input int g, input int s);
        sd_term_t t;
        t.en  = e;
        t.neg = n;
        t.grp = 3'(g);
        t.shf = 3'(s);
        return t;
    endfunction

    // Low band: 154 = 128+32-8+2, 68 = 64+4, -20 = -16-4, -4, 7 = 8-1
    function automatic sd_term_t low_term(input int i);
        case (i)
            0:       return mk_term(1, 0, 0, 7);
            1:       return mk_term(1, 0, 0, 5);
            2:       return mk_term(1, 1, 0, 3);
            3:       return mk_term(1, 0, 0, 1);
            4:       return mk_term(1, 0, 1, 6);
            5:       return mk_term(1, 0, 1, 2);
            6:       return mk_term(1, 1, 2, 4);
            7:       return mk_term(1, 1, 2, 2);
            8:       return mk_term(1, 1, 3, 2);
            9:       return mk_term(1, 0, 4, 3);
            10:      return mk_term(1, 1, 4, 0);
            default: return mk_term(0, 0, 0, 0);
        endcase
    endfunction

    // High band: 143 = 128+16-1, -76 = -64-8-4, -7 = -8+1, 12 = 8+4
    function automatic sd_term_t high_term(input int i);
        case (i)
            0:       return mk_term(1, 0, 0, 7);
            1:       return mk_term(1, 0, 0, 4);
            2:       return mk_term(1, 1, 0, 0);
            3:       return mk_term(1, 1, 1, 6);
            4:       return mk_term(1, 1, 1, 3);
            5:       return mk_term(1, 1, 1, 2);
            6:       return mk_term(1, 1, 2, 3);
            7:       return mk_term(1, 0, 2, 0);
            8:       return mk_term(1, 0, 3, 3);
            9:       return mk_term(1, 0, 3, 2);
            default: return mk_term(0, 0, 0, 0);
        endcase
    endfunction

    // Rounded expected value of the dropped columns, each bit taken as 0 or 1
    // with equal chance: a term shifted by s loses bits s..trunc-1.
    function automatic int band_bias(input bit hi, input int trunc);
        int       acc;
        int       low_edge;
        sd_term_t t;
        acc = 0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            t = hi ? high_term(i) : low_term(i);
            if (t.en) begin
                low_edge = (int'(t.shf) < trunc) ? int'(t.shf) : trunc;
                acc += (1 << trunc) - (1 << low_edge);
            end
        end
        return (acc + 1) >>> 1;
    endfunction

endpackage

// File: rtl/dwt97_sample_buf.sv
`timescale 1ns/1ps
// dwt97_sample_buf: holds one block of samples and presents the nine-sample
// window around a centre index, mirrored at both block ends without repeating
// the edge sample. Assumes BLK_LEN >= 6 so a single reflection suffices.
module dwt97_sample_buf #(
    parameter int BLK_LEN  = 16,
    parameter int SAMPLE_W = 8,
    parameter int IDX_W    = $clog2(BLK_LEN)
) (
    input  logic                               clk,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [SAMPLE_W-1:0]                wr_data,
    input  logic [IDX_W-1:0]                   centre,
    output logic [dwt97_pkg::WIN_LEN-1:0][SAMPLE_W-1:0] win
);
    import dwt97_pkg::*;

    localparam int HALF = WIN_LEN / 2;

    logic [SAMPLE_W-1:0] mem [BLK_LEN];

    // Store each accepted sample at its block position.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar j = 0; j < WIN_LEN; j++) begin : g_tap
        int          pos;
        logic [IDX_W-1:0] rd_idx;

        // Reflect the tap position into the block.
        always_comb begin
            pos = int'(centre) - HALF + j;
            if (pos < 0) begin
                pos = -pos;
            end else if (pos > BLK_LEN - 1) begin
                pos = 2 * (BLK_LEN - 1) - pos;
            end
            rd_idx = IDX_W'(pos);
        end

        assign win[j] = mem[rd_idx];
    end

endmodule

// File: rtl/dwt97_fold.sv
`timescale 1ns/1ps
// dwt97_fold: butterfly pre-adder. Sums each pair of samples that sit at equal
// distance from the centre, so only five distinct weights remain.
// Assumes unsigned samples; the group width grows by one bit.
module dwt97_fold #(
    parameter int SAMPLE_W = 8,
    parameter int GRP_W    = SAMPLE_W + 1
) (
    input  logic [dwt97_pkg::WIN_LEN-1:0][SAMPLE_W-1:0]    win,
    output logic [dwt97_pkg::NUM_GROUPS-1:0][GRP_W-1:0]    grp
);
    import dwt97_pkg::*;

    localparam int HALF = WIN_LEN / 2;

    assign grp[0] = GRP_W'(win[HALF]);

    for (genvar d = 1; d < NUM_GROUPS; d++) begin : g_pair
        assign grp[d] = GRP_W'(win[HALF - d]) + GRP_W'(win[HALF + d]);
    end

endmodule

// File: rtl/dwt97_shift_net.sv
`timescale 1ns/1ps
// dwt97_shift_net: hardwired shift network. Each slot forms one signed
// power-of-two term for the low band and one for the high band, picks the
// band in use and clears the TRUNC_COLS dropped columns.
// Assumes ACC_W holds GRP_W + 8 bits plus sign.
module dwt97_shift_net #(
    parameter int GRP_W      = 9,
    parameter int ACC_W      = 20,
    parameter int TRUNC_COLS = 4
) (
    input  logic                                          hi_sel,
    input  logic [dwt97_pkg::NUM_GROUPS-1:0][GRP_W-1:0]   grp,
    output logic [dwt97_pkg::NUM_SLOTS-1:0][ACC_W-1:0]    terms
);
    import dwt97_pkg::*;

    localparam logic [ACC_W-1:0] KEEP_MASK = ~((ACC_W'(1) << TRUNC_COLS) - ACC_W'(1));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam sd_term_t LO = low_term(i);
        localparam sd_term_t HI = high_term(i);

        logic [ACC_W-1:0] lo_t;
        logic [ACC_W-1:0] hi_t;

        // Fixed shift and sign for the low-band digit of this slot.
        always_comb begin
            lo_t = ACC_W'(grp[LO.grp]) << LO.shf;
            if (LO.neg)  lo_t = -lo_t;
            if (!LO.en)  lo_t = '0;
        end

        // Fixed shift and sign for the high-band digit of this slot.
        always_comb begin
            hi_t = ACC_W'(grp[HI.grp]) << HI.shf;
            if (HI.neg)  hi_t = -hi_t;
            if (!HI.en)  hi_t = '0;
        end

        assign terms[i] = (hi_sel ? hi_t : lo_t) & KEEP_MASK;
    end

endmodule

// File: rtl/dwt97_csa_sum.sv
`timescale 1ns/1ps
// dwt97_csa_sum: carry-save reduction of N_IN operands with 3:2 full-adder
// rows (no carry ripple inside a row) and one carry-propagate adder at the end.
// Arithmetic is modulo 2^ACC_W; assumes N_IN >= 3.
module dwt97_csa_sum #(
    parameter int N_IN  = 12,
    parameter int ACC_W = 20
) (
    input  logic [N_IN-1:0][ACC_W-1:0] ops,
    output logic [ACC_W-1:0]           total
);
    localparam int ROWS = N_IN - 1;

    logic [ROWS-1:0][ACC_W-1:0] sum_v;
    logic [ROWS-1:0][ACC_W-1:0] car_v;

    assign sum_v[0] = ops[0];
    assign car_v[0] = ops[1];

    for (genvar k = 1; k < ROWS; k++) begin : g_row
        logic [ACC_W-1:0] a_in;
        logic [ACC_W-1:0] b_in;
        logic [ACC_W-1:0] x_in;
        assign a_in     = sum_v[k-1];
        assign b_in     = car_v[k-1];
        assign x_in     = ops[k+1];
        assign sum_v[k] = a_in ^ b_in ^ x_in;
        assign car_v[k] = ((a_in & b_in) | (a_in & x_in) | (b_in & x_in)) << 1;
    end

    assign total = sum_v[ROWS-1] + car_v[ROWS-1];

endmodule

// File: rtl/dwt97_analysis.sv
`timescale 1ns/1ps
// dwt97_analysis: one-level 1-D 9/7 wavelet analysis. Collects BLK_LEN
// samples, then emits BLK_LEN coefficients (low, high, low, ...) one per
// cycle with mirrored block edges. Assumes BLK_LEN even and >= 6, and
// OUT_W >= SAMPLE_W + 11 so the kept columns cannot overflow.
module dwt97_analysis #(
    parameter int BLK_LEN    = 16,
    parameter int SAMPLE_W   = 8,
    parameter int OUT_W      = 20,
    parameter int TRUNC_COLS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [SAMPLE_W-1:0]        in_data,
    output logic                       out_valid,
    output logic                       out_hi,
    output logic signed [OUT_W-1:0]    out_data
);
    import dwt97_pkg::*;

    localparam int IDX_W   = $clog2(BLK_LEN);
    localparam int GRP_W   = SAMPLE_W + 1;
    localparam int N_OPS   = NUM_SLOTS + 1;
    localparam int LO_BIAS = band_bias(1'b0, TRUNC_COLS);
    localparam int HI_BIAS = band_bias(1'b1, TRUNC_COLS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN - 1);

    typedef enum logic {ST_FILL, ST_EMIT} state_t;

    state_t                                 state;
    logic [IDX_W-1:0]                       fill_cnt;
    logic [IDX_W-1:0]                       emit_cnt;
    logic                                   accept;
    logic                                   hi_sel;
    logic [WIN_LEN-1:0][SAMPLE_W-1:0]       win;
    logic [NUM_GROUPS-1:0][GRP_W-1:0]       grp;
    logic [NUM_SLOTS-1:0][OUT_W-1:0]        terms;
    logic [N_OPS-1:0][OUT_W-1:0]            ops;
    logic [OUT_W-1:0]                       total;

    assign in_ready = (state == ST_FILL);
    assign accept   = in_valid && in_ready;
    assign hi_sel   = emit_cnt[0];

    // Sequencer: count samples in, then count coefficients out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
            emit_cnt <= '0;
        end else begin
            case (state)
                ST_FILL: begin
                    if (accept) begin
                        if (fill_cnt == LAST_IDX) begin
                            fill_cnt <= '0;
                            emit_cnt <= '0;
                            state    <= ST_EMIT;
                        end else begin
                            fill_cnt <= fill_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    emit_cnt <= emit_cnt + 1'b1;
                    if (emit_cnt == LAST_IDX) begin
                        state <= ST_FILL;
                    end
                end
            endcase
        end
    end

    dwt97_sample_buf #(
        .BLK_LEN  (BLK_LEN),
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (fill_cnt),
        .wr_data (in_data),
        .centre  (emit_cnt),
        .win     (win)
    );

    dwt97_fold #(
        .SAMPLE_W (SAMPLE_W),
        .GRP_W    (GRP_W)
    ) u_fold (
        .win (win),
        .grp (grp)
    );

    dwt97_shift_net #(
        .GRP_W      (GRP_W),
        .ACC_W      (OUT_W),
        .TRUNC_COLS (TRUNC_COLS)
    ) u_shift (
        .hi_sel (hi_sel),
        .grp    (grp),
        .terms  (terms)
    );

    assign ops[0]         = hi_sel ? OUT_W'(HI_BIAS) : OUT_W'(LO_BIAS);
    assign ops[N_OPS-1:1] = terms;

    dwt97_csa_sum #(
        .N_IN  (N_OPS),
        .ACC_W (OUT_W)
    ) u_sum (
        .ops   (ops),
        .total (total)
    );

    // Output register: one coefficient per emit cycle with its band tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hi    <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state == ST_EMIT);
            out_hi    <= hi_sel;
            out_data  <= signed'(total);
        end
    end

    // R4
    first_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && fill_cnt == LAST_IDX) |=> (!out_valid ##1 (out_valid && !out_hi)));

    // R5
    band_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_hi != $past(out_hi)));

    // R3
    refused_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> $stable(fill_cnt));

    // R4
    busy_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !in_ready);

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(accept));

endmodule

// File: tb/dwt97_analysis_tb.sv
`timescale 1ns/1ps
module dwt97_analysis_tb;

    localparam int N  = 16;
    localparam int SW = 8;
    localparam int OW = 20;
    localparam int TC = 4;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_data  = '0;
    logic          rdy_a, rdy_b, ov_a, ov_b, hi_a, hi_b;
    logic signed [OW-1:0] d_a, d_b;

    int checks  = 0;
    int errors  = 0;
    int blk [N];
    int lo_c [5] = '{154, 68, -20, -4, 7};
    int hi_c [4] = '{143, -76, -7, 12};
    int err_sum  = 0;
    int err_cnt  = 0;
    bit track_mean = 1'b0;
    int lcg = 32'h1357;

    always #2.5 clk = ~clk;

    dwt97_analysis #(.BLK_LEN(N), .SAMPLE_W(SW), .OUT_W(OW), .TRUNC_COLS(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a), .in_data(in_data),
        .out_valid(ov_a), .out_hi(hi_a), .out_data(d_a));

    dwt97_analysis #(.BLK_LEN(N), .SAMPLE_W(SW), .OUT_W(OW), .TRUNC_COLS(TC)) u_dut_tr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b), .in_data(in_data),
        .out_valid(ov_b), .out_hi(hi_b), .out_data(d_b));

    function automatic int xm(int i);
        int p = i;
        if (p < 0) p = -p;
        else if (p > N - 1) p = 2 * (N - 1) - p;
        return blk[p];
    endfunction

    // Arithmetic model of R6 / R7 with the mirrored edges of R8.
    function automatic int ref_out(int c);
        int acc;
        if (c % 2 == 0) begin
            acc = lo_c[0] * xm(c);
            for (int t = 1; t < 5; t++) acc += lo_c[t] * (xm(c - t) + xm(c + t));
        end else begin
            acc = hi_c[0] * xm(c);
            for (int t = 1; t < 4; t++) acc += hi_c[t] * (xm(c - t) + xm(c + t));
        end
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Feed one block (optionally with idle cycles), then check all outputs.
    task automatic run_block(input bit gaps);
        int e, err, bound;
        string tag;
        for (int i = 0; i < N; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 8'h5A;
            end
            @(negedge clk);
            chk(rdy_a && rdy_b, "R2", int'(rdy_a), 1);
            chk(!ov_a && !ov_b, "R4", int'(ov_a), 0);
            in_valid = 1'b1;
            in_data  = SW'(blk[i]);
        end
        @(negedge clk);
        chk(!ov_a && !ov_b, "R4", int'(ov_a), 0);
        chk(!rdy_a && !rdy_b, "R2", int'(rdy_a), 0);
        in_valid = 1'b1;          // refused garbage, R3
        in_data  = 8'hC3;
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            chk(ov_a && ov_b, "R4", int'(ov_a), 1);
            chk(hi_a == j[0] && hi_b == j[0], "R5", int'(hi_a), j % 2);
            e = ref_out(j);
            if (j < 4 || j > N - 5) tag = "R8";
            else if (j % 2 == 0)    tag = "R6";
            else                    tag = "R7";
            chk(int'(d_a) == e, tag, int'(d_a), e);
            err   = int'(d_b) - e;
            bound = 11 << TC;
            chk(err <= bound && err >= -bound, "R9", err, bound);
            if (track_mean) begin
                err_sum += err;
                err_cnt++;
            end
            if (j == N - 1) chk(rdy_a && rdy_b, "R4", int'(rdy_a), 1);
            in_valid = !rdy_a;    // offer garbage only while refused, R3
            in_data  = SW'(8'hFF - j);
        end
        in_valid = 1'b0;
    endtask

    task automatic next_rand(output int v);
        lcg = lcg * 1103515245 + 12345;
        v = (lcg >>> 16) & 255;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R4 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int v;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk(!ov_a && !ov_b, "R1", int'(ov_a), 0);
        chk(rdy_a && rdy_b, "R1", int'(rdy_a), 1);
        rst_n = 1'b1;

        // Partial block, then reset: R1 discards it.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'd99;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        chk(!ov_a && rdy_a, "R1", int'(ov_a), 0);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) blk[i] = i * 16;
        run_block(1'b1);
        for (int i = 0; i < N; i++) blk[i] = 255;
        run_block(1'b0);
        for (int i = 0; i < N; i++) blk[i] = 0;
        run_block(1'b0);
        for (int i = 0; i < N; i++) blk[i] = (i % 2) ? 255 : 0;
        run_block(1'b1);
        for (int i = 0; i < N; i++) blk[i] = (i < N / 2) ? 10 : 240;
        run_block(1'b0);
        for (int p = 0; p < N; p++) begin
            for (int i = 0; i < N; i++) blk[i] = (i == p) ? 255 : 0;
            run_block(p % 2 == 1);
        end
        track_mean = 1'b1;
        for (int b = 0; b < 40; b++) begin
            for (int i = 0; i < N; i++) begin
                next_rand(v);
                blk[i] = v;
            end
            run_block(b % 4 == 0);
        end
        // R10: bias keeps the mean error small
        chk((err_sum <= (err_cnt << TC) / 2) && (err_sum >= -((err_cnt << TC) / 2)),
            "R10", err_sum, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule